// File: doc/BRIEF.md
# Bus-Attached Serial Byte Port

This block joins a processor bus to a two-wire asynchronous serial link. It is a slave on a 32-bit Wishbone classic bus. A processor writes one byte to send it on the transmit wire. It reads one byte back once a complete character has come in on the receive wire. Each character on the wire is one low start bit, eight data bits with the least significant bit first, and one high stop bit. The line rests high between characters. Every bit lasts `CLKS_PER_BIT` clock cycles. The default of 347 gives roughly 115200 baud from a 40 MHz clock.

The block decodes two words at `BASE_ADDR`. The word at the base address is the data register. The character occupies byte lane 3 (bits 31:24), and a write must assert byte select 3 to count. The word at base + 4 is read-only status. It holds two set/reset flags: one says the transmitter is empty, the other says the receiver holds an unread byte. Software polls these flags to pace its own transfers. The block acknowledges each access in a single cycle, and read data and write data travel on separate buses.

Top module: `uart_wb`

## Requirements
- R1: While reset is high, and afterwards until the first access, the block holds these values: the transmit line is 1, the acknowledge is 0, and a status read returns 0x2000_0000 (transmitter empty, receiver not full).
- R2: An access with cyc and stb high to BASE_ADDR or BASE_ADDR+4 is acknowledged with ack high in the clock cycle that follows the request, for exactly one cycle. An access to any other word is never acknowledged.
- R3: A write to BASE_ADDR with we and sel[3] high, made while the transmitter is empty, sends dat_i[31:24]. The frame is a 0 start bit, then data bits 0 to 7, then a 1 stop bit, and each bit lasts CLKS_PER_BIT cycles.
- R4: The transmit-empty flag clears when a byte is accepted. It stays clear until the stop bit has been on the line for its full CLKS_PER_BIT cycles, and then it sets again.
- R5: These writes leave both the line and the flags unchanged: a write to BASE_ADDR without sel[3], a write to BASE_ADDR while a frame is in progress, and any write to BASE_ADDR+4.
- R6: A status read at BASE_ADDR+4 returns the transmit-empty flag in bit 29 and the receive-full flag in bit 28. Every other bit reads 0.
- R7: The receiver detects a falling edge on the receive line and checks the start bit at half a bit time. It then samples each data bit at mid-bit, least significant bit first. After a valid stop bit it sets the receive-full flag. A read of BASE_ADDR then returns the byte in bits 31:24, with bits 23:0 at 0.
- R8: A read of BASE_ADDR clears the receive-full flag. A read of BASE_ADDR+4 does not clear it.
- R9: A low pulse on the receive line shorter than half a bit time is treated as noise. It delivers no byte.
- R10: A frame whose stop bit samples 0 is discarded, and the receive-full flag stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_adr_i | input | 32 | Bus byte address |
| wb_dat_i | input | 32 | Write data from master |
| wb_dat_o | output | 32 | Read data to master |
| wb_we_i | input | 1 | Write enable |
| wb_sel_i | input | 4 | Byte lane selects |
| wb_stb_i | input | 1 | Strobe |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_ack_o | output | 1 | Single-cycle acknowledge |
| ser_tx_o | output | 1 | Serial transmit line |
| ser_rx_i | input | 1 | Serial receive line |

## Verification
The transmitter is tried with every one of the 256 byte values. A bench monitor decodes each one from the line at mid-bit, which shows any misordered bit, stuck bit or wrong bit time. The receiver is also fed all 256 values. Each is read back through the status and data words, which separates flag-handling faults from data-path faults. Extra stimulus covers the cases that must not act: a write without sel[3], a write while the transmitter is busy, a write to the status word, a short noise pulse, a frame with a low stop bit, and an access to an unmapped word. Each case shows whether gating, qualification or decoding is missing.

// File: rtl/uart_pkg.sv
package uart_pkg;

    localparam int BYTE_W      = 8;
    localparam int BUS_W       = 32;
    localparam int LANE_LO     = BUS_W - BYTE_W;   // data byte sits in top lane
    localparam int TXE_POS     = 29;
    localparam int RXF_POS     = 28;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic [BUS_W-1:0] adr;
        logic [BUS_W-1:0] dat;
        logic             we;
        logic [3:0]       sel;
        logic             stb;
        logic             cyc;
    } bus_req_t;

    function automatic logic [BUS_W-1:0] pack_status(input logic txe, input logic rxf);
        logic [BUS_W-1:0] w;
        w          = '0;
        w[TXE_POS] = txe;
        w[RXF_POS] = rxf;
        return w;
    endfunction

    function automatic logic [BUS_W-1:0] pack_byte(input logic [BYTE_W-1:0] b);
        return {b, {LANE_LO{1'b0}}};
    endfunction

endpackage

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_pkg::*;
#(
    parameter int CLKS_PER_BIT = 347
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              line_o,
    output logic              frame_done
);
    localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    tx_state_e         state;
    logic [CW-1:0]     tick;
    logic [2:0]        bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic              line_q;
    logic              bit_end;

    assign bit_end    = (tick == LAST);
    assign frame_done = (state == TX_STOP) && bit_end;
    assign line_o     = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_IDLE;
            tick    <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            line_q  <= 1'b1;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (load) begin
                        state   <= TX_START;
                        shreg   <= load_byte;
                        tick    <= '0;
                        bit_idx <= '0;
                        line_q  <= 1'b0;
                    end
                end
                TX_START: begin
                    tick <= bit_end ? '0 : tick + 1'b1;
                    if (bit_end) begin
                        state  <= TX_DATA;
                        line_q <= shreg[0];
                    end
                end
                TX_DATA: begin
                    tick <= bit_end ? '0 : tick + 1'b1;
                    if (bit_end) begin
                        if (bit_idx == 3'd7) begin
                            state  <= TX_STOP;
                            line_q <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            shreg   <= {1'b0, shreg[BYTE_W-1:1]};
                            line_q  <= shreg[1];
                        end
                    end
                end
                TX_STOP: begin
                    tick <= bit_end ? '0 : tick + 1'b1;
                    if (bit_end) state <= TX_IDLE;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R3
    load_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (state == TX_IDLE));

    // R4
    stop_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TX_STOP) |-> line_q);

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE) |-> line_q);

endmodule

// File: rtl/uart_rx_sample.sv
module uart_rx_sample
    import uart_pkg::*;
#(
    parameter int CLKS_PER_BIT = 347
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_done
);
    localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2 - 1);

    rx_state_e         state;
    logic [2:0]        sync;
    logic [CW-1:0]     tick;
    logic [2:0]        bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] hold;
    logic              done_q;
    logic              line_s;
    logic              fall;

    assign line_s    = sync[1];
    assign fall      = sync[2] & ~sync[1];
    assign rx_byte   = hold;
    assign byte_done = done_q;

    always_ff @(posedge clk) begin
        if (rst) sync <= 3'b111;
        else     sync <= {sync[1:0], line_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            tick    <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            hold    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    tick <= '0;
                    if (fall) state <= RX_START;
                end
                RX_START: begin
                    if (tick == HALF) begin
                        tick    <= '0;
                        bit_idx <= '0;
                        state   <= line_s ? RX_IDLE : RX_DATA;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (tick == LAST) begin
                        tick  <= '0;
                        shreg <= {line_s, shreg[BYTE_W-1:1]};
                        if (bit_idx == 3'd7) state <= RX_STOP;
                        else                 bit_idx <= bit_idx + 1'b1;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (tick == LAST) begin
                        tick  <= '0;
                        state <= RX_IDLE;
                        if (line_s) begin
                            hold   <= shreg;
                            done_q <= 1'b1;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(hold) || $past(state) == RX_STOP);

    // R10
    done_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(state) == RX_STOP);

endmodule

// File: rtl/uart_bus_regs.sv
module uart_bus_regs
    import uart_pkg::*;
#(
    parameter logic [BUS_W-1:0] BASE_ADDR = 32'h9000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              tx_done,
    input  logic              rx_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [BUS_W-1:0]  dat_o,
    output logic              ack_o
);
    logic             ack_q;
    logic [BUS_W-1:0] dat_q;
    logic             tx_empty_q;
    logic             rx_full_q;
    logic             hit;
    logic             go;
    logic             at_data;
    logic             rx_clear;
    logic             unused_bits;

    assign hit      = (req.adr[BUS_W-1:3] == BASE_ADDR[BUS_W-1:3]);
    assign at_data  = ~req.adr[2];
    assign go       = req.cyc & req.stb & hit & ~ack_q;
    assign tx_load  = go & req.we & at_data & req.sel[3] & tx_empty_q;
    assign tx_byte  = req.dat[BUS_W-1:LANE_LO];
    assign rx_clear = go & ~req.we & at_data;
    assign ack_o    = ack_q;
    assign dat_o    = dat_q;

    assign unused_bits = ^{req.adr[1:0], req.dat[LANE_LO-1:0], req.sel[2:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q      <= 1'b0;
            dat_q      <= '0;
            tx_empty_q <= 1'b1;
            rx_full_q  <= 1'b0;
        end else begin
            ack_q <= go;
            if (go && !req.we)
                dat_q <= at_data ? pack_byte(rx_byte) : pack_status(tx_empty_q, rx_full_q);
            else
                dat_q <= '0;

            if (tx_load)      tx_empty_q <= 1'b0;
            else if (tx_done) tx_empty_q <= 1'b1;

            if (rx_done)       rx_full_q <= 1'b1;
            else if (rx_clear) rx_full_q <= 1'b0;
        end
    end

    // R2
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        ack_q |-> $past(req.cyc && req.stb));

    // R4
    load_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_empty_q);

    // R8
    full_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_full_q) |-> $past(rx_clear));

    // R7
    full_set_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full_q) |-> $past(rx_done));

endmodule

// File: rtl/uart_wb.sv
module uart_wb
    import uart_pkg::*;
#(
    parameter int               CLKS_PER_BIT = 347,
    parameter logic [31:0]      BASE_ADDR    = 32'h9000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] wb_adr_i,
    input  logic [31:0] wb_dat_i,
    output logic [31:0] wb_dat_o,
    input  logic        wb_we_i,
    input  logic [3:0]  wb_sel_i,
    input  logic        wb_stb_i,
    input  logic        wb_cyc_i,
    output logic        wb_ack_o,
    output logic        ser_tx_o,
    input  logic        ser_rx_i
);
    bus_req_t          req;
    logic              tx_load;
    logic [BYTE_W-1:0] tx_byte;
    logic              tx_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_done;

    assign req = '{adr: wb_adr_i, dat: wb_dat_i, we: wb_we_i,
                   sel: wb_sel_i, stb: wb_stb_i, cyc: wb_cyc_i};

    uart_bus_regs #(.BASE_ADDR(BASE_ADDR)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .tx_done (tx_done),
        .rx_done (rx_done),
        .rx_byte (rx_byte),
        .tx_load (tx_load),
        .tx_byte (tx_byte),
        .dat_o   (wb_dat_o),
        .ack_o   (wb_ack_o)
    );

    uart_tx_shift #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .load       (tx_load),
        .load_byte  (tx_byte),
        .line_o     (ser_tx_o),
        .frame_done (tx_done)
    );

    uart_rx_sample #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .line_i    (ser_rx_i),
        .rx_byte   (rx_byte),
        .byte_done (rx_done)
    );

endmodule

// File: tb/uart_wb_bench.sv
module uart_wb_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          DIV        = 8;
    localparam logic [31:0] BASE       = 32'h9000_0000;
    localparam logic [31:0] STAT       = 32'h9000_0004;
    localparam logic [31:0] ST_IDLE    = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] adr = '0;
    logic [31:0] wdat = '0;
    logic [31:0] rdat;
    logic        we = 1'b0;
    logic [3:0]  sel = '0;
    logic        stb = 1'b0;
    logic        cyc = 1'b0;
    logic        ack;
    logic        tx;
    logic        rx = 1'b1;

    int checks = 0;
    int fails  = 0;
    int mon_cnt = 0;
    logic [7:0] mon_byte = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_wb #(.CLKS_PER_BIT(DIV), .BASE_ADDR(BASE)) u_uart_wb (
        .clk(clk), .rst(rst), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat),
        .wb_we_i(we), .wb_sel_i(sel), .wb_stb_i(stb), .wb_cyc_i(cyc),
        .wb_ack_o(ack), .ser_tx_o(tx), .ser_rx_i(rx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_access(input logic [31:0] a, input logic w,
                              input logic [31:0] d, input logic [3:0] s,
                              output logic [31:0] q);
        int n;
        @(negedge clk);
        adr = a; we = w; wdat = d; sel = s; cyc = 1'b1; stb = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ack && n < 8);
        q = rdat;
        // R2 acknowledge one cycle after the request
        chk("R2 ack latency", 32'(n), 32'd1);
        cyc = 1'b0; stb = 1'b0; we = 1'b0; sel = '0;
        @(negedge clk);
        chk("R2 ack width", {31'd0, ack}, 32'd0);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] q;
        bus_access(a, 1'b1, d, s, q);
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] q);
        bus_access(a, 1'b0, '0, 4'hF, q);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        @(negedge clk);
        rx = 1'b0;
        repeat (DIV) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (DIV) @(negedge clk);
        end
        rx = stop;
        repeat (DIV) @(negedge clk);
        rx = 1'b1;
    endtask

    // line monitor: decodes frames on tx at mid-bit
    initial begin
        forever begin
            @(negedge tx);
            repeat (DIV/2) @(posedge clk);
            // R3 start bit
            chk("R3 start bit", {31'd0, tx}, 32'd0);
            for (int i = 0; i < 8; i++) begin
                repeat (DIV) @(posedge clk);
                mon_byte[i] = tx;
            end
            repeat (DIV) @(posedge clk);
            // R3 stop bit
            chk("R3 stop bit", {31'd0, tx}, 32'd1);
            mon_cnt++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] q;
        int c0;

        repeat (4) @(negedge clk);
        // R1 reset values
        chk("R1 tx during reset", {31'd0, tx}, 32'd1);
        chk("R1 ack during reset", {31'd0, ack}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        rd(STAT, q);
        chk("R1 status after reset", q, ST_IDLE);
        chk("R1 tx after reset", {31'd0, tx}, 32'd1);

        // R2 unmapped word: no acknowledge
        begin
            logic seen = 1'b0;
            @(negedge clk);
            adr = BASE + 32'h10; cyc = 1'b1; stb = 1'b1; we = 1'b0;
            repeat (6) begin
                @(negedge clk);
                seen |= ack;
            end
            cyc = 1'b0; stb = 1'b0;
            chk("R2 unmapped no ack", {31'd0, seen}, 32'd0);
        end

        // R3 R4 R6 transmit every byte value
        for (int b = 0; b < 256; b++) begin
            c0 = mon_cnt;
            wr(BASE, {8'(b), 24'h5A5A5A}, 4'b1000);
            rd(STAT, q);
            chk("R4 tx_empty cleared while sending", q, 32'h0);
            wait (mon_cnt == c0 + 1);
            chk("R3 transmitted byte", {24'd0, mon_byte}, 32'(b));
            repeat (DIV) @(negedge clk);
            rd(STAT, q);
            chk("R6 R4 status after frame", q, ST_IDLE);
        end

        // R5 write while busy is ignored
        c0 = mon_cnt;
        wr(BASE, 32'h3C00_0000, 4'b1000);
        wr(BASE, 32'hC300_0000, 4'b1000);
        wait (mon_cnt == c0 + 1);
        chk("R5 busy write ignored byte", {24'd0, mon_byte}, 32'h3C);
        repeat (12*DIV) @(negedge clk);
        chk("R5 busy write no second frame", 32'(mon_cnt), 32'(c0 + 1));

        // R5 write without sel[3]
        c0 = mon_cnt;
        wr(BASE, 32'h7700_0000, 4'b0111);
        rd(STAT, q);
        chk("R5 no sel3 status", q, ST_IDLE);
        repeat (12*DIV) @(negedge clk);
        chk("R5 no sel3 no frame", 32'(mon_cnt), 32'(c0));
        chk("R5 no sel3 line idle", {31'd0, tx}, 32'd1);

        // R5 write to status word
        wr(STAT, 32'hFFFF_FFFF, 4'hF);
        rd(STAT, q);
        chk("R5 status write ignored", q, ST_IDLE);
        repeat (12*DIV) @(negedge clk);
        chk("R5 status write no frame", 32'(mon_cnt), 32'(c0));

        // R7 R8 receive every byte value
        for (int b = 0; b < 256; b++) begin
            send_rx(8'(b), 1'b1);
            repeat (2) @(negedge clk);
            rd(STAT, q);
            chk("R7 rx_full set", q, 32'h3000_0000);
            rd(STAT, q);
            chk("R8 status read keeps rx_full", q, 32'h3000_0000);
            rd(BASE, q);
            chk("R7 received byte", q, {8'(b), 24'h0});
            rd(STAT, q);
            chk("R8 data read clears rx_full", q, ST_IDLE);
        end

        // R9 short noise pulse
        @(negedge clk);
        rx = 1'b0;
        repeat (2) @(negedge clk);
        rx = 1'b1;
        repeat (12*DIV) @(negedge clk);
        rd(STAT, q);
        chk("R9 glitch ignored", q, ST_IDLE);

        // R10 low stop bit discarded
        send_rx(8'hA5, 1'b0);
        repeat (2*DIV) @(negedge clk);
        rd(STAT, q);
        chk("R10 bad stop discarded", q, ST_IDLE);

        // R7 receiver recovers after bad frame
        send_rx(8'h96, 1'b1);
        repeat (2) @(negedge clk);
        rd(BASE, q);
        chk("R7 byte after bad frame", q, 32'h9600_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule